// File: doc/BRIEF.md
# Per-Read Candidate Deduplication Filter

The block takes in the candidate alignment locations produced for one sequence read and passes each distinct location downstream once. Any location already seen for the current read is dropped. A read begins with a start command that carries its ID, its data and the number of seeds to expect. The block accepts a start only once the previous read is fully processed, so the producer stalls on that handshake. When a start is accepted, the read header is placed on the output before any candidate of that read.

Each seed first sends a count message that gives the number of candidates it will produce, which may be zero. Candidates then arrive one at a time. The block counts the count messages against the seed total and the candidates against the sum of the announced counts, and from these two totals it knows when the read is finished.

Membership is held in a small hash table on chip. The table uses linear probing over a fixed number of slots. It is emptied at each new read by advancing a generation tag. When every probed slot is taken, the candidate is still forwarded but is not stored. This can produce a duplicate but never loses a candidate.

Top module: `cand_dedup_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid_o is 0, start_ready_o is 1, cnt_ready_o is 0 and cand_ready_o is 0.
- R2: start_ready_o is 1 only when two conditions hold. First, the current read is complete (see R10). Second, the output register is empty or is being drained this cycle (out_ready_i is 1). While a read is incomplete, a held start request is not accepted.
- R3: In the cycle after a start is accepted, out_valid_o is 1 and out_is_read_o is 1. At that point out_id_o and out_read_o equal the accepted read ID and read data.
- R4: cnt_ready_o is 1 while the number of count messages accepted for the current read is below the read's seed total. A count of zero still counts as one seed message.
- R5: cand_ready_o is 1 only when two conditions hold. First, the candidates accepted for the read are fewer than the sum of the counts accepted so far. Second, the output register is empty or is draining.
- R6: When a candidate is accepted and is not in the table, it appears in the next cycle with out_valid_o set to 1, out_is_read_o set to 0, out_cand_o holding the candidate and out_id_o holding the current read ID.
- R7: When a candidate is accepted and is already in the table for the current read, the block produces no output for it.
- R8: Accepting a start empties the table, so a value seen in an earlier read is forwarded again in the new read.
- R9: The home slot of a candidate is the XOR of all candidate bits b folded onto bit (b mod IDX_W), where IDX_W = log2(DEPTH). PROBES consecutive slots are tried, wrapping modulo DEPTH. If all of them hold other values of the current read, the candidate is forwarded but not stored, so a repeat of it is forwarded again.
- R10: A read is complete when two equalities hold: the count messages equal the seed total, and the candidates equal the sum of counts. A read with zero seeds is complete as soon as it starts.
- R11: While out_valid_o is 1 and out_ready_i is 0, all output fields stay unchanged and out_valid_o stays 1.
- R12: The table stays correct across any number of reads, including when the generation tag wraps. A value inserted 2^GEN_W reads earlier is not treated as present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_valid_i | input | 1 | Start command valid |
| start_ready_o | output | 1 | Start accepted (previous read complete) |
| start_id_i | input | ID_W | Read ID |
| start_read_i | input | READ_W | Read data |
| start_seeds_i | input | SEEDS_W | Number of seeds for the read |
| cnt_valid_i | input | 1 | Seed count message valid |
| cnt_ready_o | output | 1 | Seed count message accepted |
| cnt_num_i | input | CNT_W | Candidates that will follow for this seed |
| cand_valid_i | input | 1 | Candidate valid |
| cand_ready_o | output | 1 | Candidate accepted |
| cand_i | input | CAND_W | Candidate location |
| out_valid_o | output | 1 | Output valid |
| out_ready_i | input | 1 | Downstream ready |
| out_is_read_o | output | 1 | 1: read header, 0: forwarded candidate |
| out_id_o | output | ID_W | Read ID of the header or candidate |
| out_read_o | output | READ_W | Read data (meaningful on headers) |
| out_cand_o | output | CAND_W | Forwarded candidate (meaningful when out_is_read_o is 0) |

## Verification
Two pairs of events can occur in the same cycle and both are exercised. In the first pair, a count message and a candidate are accepted together: the sum and the candidate counter then move at once, and the candidate gate must use the sum from before that count. In the second pair, the last candidate of a read is accepted while a start request for the next read is already held. The count and candidate streams are driven from parallel processes, so they overlap freely. A start is held high across the tail of an incomplete read, and downstream ready is toggled at random. A behavioural model judges every ready, valid and output field on every clock. It tracks the read totals and a plain list of live table entries, which it empties at each start.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  typedef enum logic {
    OUT_CAND = 1'b0,
    OUT_READ = 1'b1
  } out_kind_e;
endpackage

// File: rtl/cdf_member_tbl.sv
module cdf_member_tbl #(
  parameter int CAND_W = 16,
  parameter int DEPTH  = 16,
  parameter int PROBES = 2,
  parameter int GEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CAND_W-1:0] look_i,
  input  logic              insert_i,
  output logic              hit_o,
  output logic              room_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              ent_val_q [DEPTH];
  logic [GEN_W-1:0]  ent_gen_q [DEPTH];
  logic [CAND_W-1:0] ent_tag_q [DEPTH];
  logic [GEN_W-1:0]  gen_q;

  logic [IDX_W-1:0]  home;
  logic [IDX_W-1:0]  slot  [PROBES];
  logic [PROBES-1:0] match;
  logic [PROBES-1:0] vacant;
  logic [IDX_W-1:0]  ins_slot;

  always_comb begin
    home = '0;
    for (int b = 0; b < CAND_W; b++) home[b % IDX_W] = home[b % IDX_W] ^ look_i[b];
  end

  for (genvar p = 0; p < PROBES; p++) begin : g_probe
    logic live;
    assign slot[p]   = home + IDX_W'(p);
    assign live      = ent_val_q[slot[p]] && (ent_gen_q[slot[p]] == gen_q);
    assign match[p]  = live && (ent_tag_q[slot[p]] == look_i);
    assign vacant[p] = !live;
  end

  assign hit_o  = |match;
  assign room_o = |vacant;

  // first vacant probe wins
  always_comb begin
    ins_slot = slot[0];
    for (int p = PROBES - 1; p >= 0; p--) if (vacant[p]) ins_slot = slot[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_val_q[i] <= 1'b0;
    end else if (clear_i) begin
      gen_q <= gen_q + 1'b1;
      // on wrap, stale tags could alias the new generation
      if (&gen_q) for (int i = 0; i < DEPTH; i++) ent_val_q[i] <= 1'b0;
    end else if (insert_i && room_o) begin
      ent_val_q[ins_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!clear_i && insert_i && room_o) begin
      ent_gen_q[ins_slot] <= gen_q;
      ent_tag_q[ins_slot] <= look_i;
    end
  end
endmodule

// File: rtl/cdf_count_trk.sv
module cdf_count_trk #(
  parameter int SEEDS_W = 6,
  parameter int CNT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SEEDS_W-1:0] seeds_i,
  input  logic               cnt_i,
  input  logic [CNT_W-1:0]   cnt_num_i,
  input  logic               cand_i,
  output logic               done_o,
  output logic               cnt_room_o,
  output logic               cand_room_o
);
  localparam int SUM_W = CNT_W + SEEDS_W;

  logic [SEEDS_W-1:0] seeds_q, seen_seeds_q;
  logic [SUM_W-1:0]   sum_q, seen_cands_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeds_q      <= '0;
      seen_seeds_q <= '0;
      sum_q        <= '0;
      seen_cands_q <= '0;
    end else if (start_i) begin
      seeds_q      <= seeds_i;
      seen_seeds_q <= '0;
      sum_q        <= '0;
      seen_cands_q <= '0;
    end else begin
      if (cnt_i) begin
        seen_seeds_q <= seen_seeds_q + 1'b1;
        sum_q        <= sum_q + SUM_W'(cnt_num_i);
      end
      if (cand_i) seen_cands_q <= seen_cands_q + 1'b1;
    end
  end

  assign cnt_room_o  = seen_seeds_q < seeds_q;
  assign cand_room_o = seen_cands_q < sum_q;
  assign done_o      = (seen_seeds_q == seeds_q) && (seen_cands_q == sum_q);
endmodule

// File: rtl/cdf_out_reg.sv
module cdf_out_reg
  import cdf_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int READ_W = 32,
  parameter int CAND_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hdr_i,
  input  logic              load_cand_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [READ_W-1:0] read_i,
  input  logic [CAND_W-1:0] cand_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic              is_read_o,
  output logic [ID_W-1:0]   id_o,
  output logic [READ_W-1:0] read_o,
  output logic [CAND_W-1:0] cand_o
);
  out_kind_e kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_q  <= OUT_CAND;
      id_o    <= '0;
      read_o  <= '0;
      cand_o  <= '0;
    end else if (load_hdr_i) begin
      valid_o <= 1'b1;
      kind_q  <= OUT_READ;
      id_o    <= id_i;
      read_o  <= read_i;
    end else if (load_cand_i) begin
      valid_o <= 1'b1;
      kind_q  <= OUT_CAND;
      cand_o  <= cand_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign is_read_o = (kind_q == OUT_READ);
  assign free_o    = !valid_o || ready_i;
endmodule

// File: rtl/cand_dedup_filter.sv
module cand_dedup_filter #(
  parameter int ID_W    = 8,
  parameter int READ_W  = 32,
  parameter int CAND_W  = 16,
  parameter int SEEDS_W = 6,
  parameter int CNT_W   = 6,
  parameter int DEPTH   = 16,
  parameter int PROBES  = 2,
  parameter int GEN_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_valid_i,
  output logic               start_ready_o,
  input  logic [ID_W-1:0]    start_id_i,
  input  logic [READ_W-1:0]  start_read_i,
  input  logic [SEEDS_W-1:0] start_seeds_i,
  input  logic               cnt_valid_i,
  output logic               cnt_ready_o,
  input  logic [CNT_W-1:0]   cnt_num_i,
  input  logic               cand_valid_i,
  output logic               cand_ready_o,
  input  logic [CAND_W-1:0]  cand_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               out_is_read_o,
  output logic [ID_W-1:0]    out_id_o,
  output logic [READ_W-1:0]  out_read_o,
  output logic [CAND_W-1:0]  out_cand_o
);
  logic done, cnt_room, cand_room, out_free, hit, room;
  logic start_fire, cnt_fire, cand_fire, fwd;

  assign start_ready_o = done && out_free;
  assign cnt_ready_o   = cnt_room;
  assign cand_ready_o  = cand_room && out_free;

  assign start_fire = start_valid_i && start_ready_o;
  assign cnt_fire   = cnt_valid_i && cnt_ready_o;
  assign cand_fire  = cand_valid_i && cand_ready_o;
  assign fwd        = cand_fire && !hit;

  cdf_count_trk #(.SEEDS_W(SEEDS_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_fire),
    .seeds_i     (start_seeds_i),
    .cnt_i       (cnt_fire),
    .cnt_num_i   (cnt_num_i),
    .cand_i      (cand_fire),
    .done_o      (done),
    .cnt_room_o  (cnt_room),
    .cand_room_o (cand_room)
  );

  cdf_member_tbl #(.CAND_W(CAND_W), .DEPTH(DEPTH), .PROBES(PROBES), .GEN_W(GEN_W)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_fire),
    .look_i   (cand_i),
    .insert_i (fwd),
    .hit_o    (hit),
    .room_o   (room)
  );

  cdf_out_reg #(.ID_W(ID_W), .READ_W(READ_W), .CAND_W(CAND_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_hdr_i  (start_fire),
    .load_cand_i (fwd),
    .id_i        (start_id_i),
    .read_i      (start_read_i),
    .cand_i      (cand_i),
    .ready_i     (out_ready_i),
    .free_o      (out_free),
    .valid_o     (out_valid_o),
    .is_read_o   (out_is_read_o),
    .id_o        (out_id_o),
    .read_o      (out_read_o),
    .cand_o      (out_cand_o)
  );

  logic unused_room;
  assign unused_room = room;
endmodule

// File: rtl/cdf_chk.sv
module cdf_chk #(
  parameter int ID_W    = 8,
  parameter int READ_W  = 32,
  parameter int CAND_W  = 16,
  parameter int SEEDS_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_valid_i,
  input logic               start_ready_o,
  input logic [ID_W-1:0]    start_id_i,
  input logic [READ_W-1:0]  start_read_i,
  input logic [SEEDS_W-1:0] start_seeds_i,
  input logic               cnt_ready_o,
  input logic               cand_valid_i,
  input logic               cand_ready_o,
  input logic [CAND_W-1:0]  cand_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic               out_is_read_o,
  input logic [ID_W-1:0]    out_id_o,
  input logic [READ_W-1:0]  out_read_o,
  input logic [CAND_W-1:0]  out_cand_o
);
  // R3
  hdr_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_i && start_ready_o |=> out_valid_o && out_is_read_o &&
      out_id_o == $past(start_id_i) && out_read_o == $past(start_read_i));

  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_is_read_o) &&
      $stable(out_id_o) && $stable(out_read_o) && $stable(out_cand_o));

  // R5
  cand_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !cand_ready_o && !start_ready_o);

  // R6
  cand_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i && cand_ready_o |=> !out_valid_o ||
      (!out_is_read_o && out_cand_o == $past(cand_i)));

  // R2
  start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ready_o |-> !cnt_ready_o && !cand_ready_o);

  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_i && start_ready_o && start_seeds_i != '0 |=> !start_ready_o);
endmodule

bind cand_dedup_filter cdf_chk #(
  .ID_W(ID_W), .READ_W(READ_W), .CAND_W(CAND_W), .SEEDS_W(SEEDS_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_valid_i (start_valid_i),
  .start_ready_o (start_ready_o),
  .start_id_i    (start_id_i),
  .start_read_i  (start_read_i),
  .start_seeds_i (start_seeds_i),
  .cnt_ready_o   (cnt_ready_o),
  .cand_valid_i  (cand_valid_i),
  .cand_ready_o  (cand_ready_o),
  .cand_i        (cand_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_is_read_o (out_is_read_o),
  .out_id_o      (out_id_o),
  .out_read_o    (out_read_o),
  .out_cand_o    (out_cand_o)
);

// File: tb/cand_dedup_filter_tb.sv
`timescale 1ns/1ps
module cand_dedup_filter_tb;
  localparam int ID_W = 8, READ_W = 32, CAND_W = 16, SEEDS_W = 6, CNT_W = 6;
  localparam int DEPTH = 16, PROBES = 2, GEN_W = 4, IDX_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_valid_i = 1'b0, cnt_valid_i = 1'b0, cand_valid_i = 1'b0, out_ready_i = 1'b1;
  logic [ID_W-1:0] start_id_i = '0;
  logic [READ_W-1:0] start_read_i = '0;
  logic [SEEDS_W-1:0] start_seeds_i = '0;
  logic [CNT_W-1:0] cnt_num_i = '0;
  logic [CAND_W-1:0] cand_i = '0;
  logic start_ready_o, cnt_ready_o, cand_ready_o, out_valid_o, out_is_read_o;
  logic [ID_W-1:0] out_id_o;
  logic [READ_W-1:0] out_read_o;
  logic [CAND_W-1:0] out_cand_o;

  always #2 clk_i = ~clk_i;

  cand_dedup_filter u_dut (.*);

  int n_chk = 0, n_fail = 0, cycles = 0, fwd_cnt = 0, rdy_mode = 0;
  bit run_chk = 0;
  string phase = "R1";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (phase %s) %s: actual %0h expected %0h at %0t", tag, phase, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_seeds = 0, m_sseen = 0, m_sum = 0, m_cseen = 0;
  bit m_ov = 0, m_isr = 0;
  int m_id = 0, m_rd = 0, m_cd = 0;
  bit m_live [DEPTH];
  int m_tag [DEPTH];

  function automatic int fold(int c);
    int h = 0;
    for (int b = 0; b < CAND_W; b++) if (c[b]) h = h ^ (1 << (b % IDX_W));
    return h;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && run_chk) begin
      bit done, free, srdy, nrdy, crdy, sf, nf, cf, hit;
      int home, emp, s;
      done = (m_sseen == m_seeds) && (m_cseen == m_sum);
      free = !m_ov || out_ready_i;
      srdy = done && free;
      nrdy = m_sseen < m_seeds;
      crdy = (m_cseen < m_sum) && free;
      chk(start_ready_o == srdy, "R2", "start_ready_o", start_ready_o, srdy);
      chk(cnt_ready_o == nrdy, "R4", "cnt_ready_o", cnt_ready_o, nrdy);
      chk(cand_ready_o == crdy, "R5", "cand_ready_o", cand_ready_o, crdy);
      chk(out_valid_o == m_ov, "R6", "out_valid_o", out_valid_o, m_ov);
      if (m_ov) begin
        chk(out_is_read_o == m_isr, "R3", "out_is_read_o", out_is_read_o, m_isr);
        chk(out_id_o == ID_W'(m_id), "R3", "out_id_o", out_id_o, m_id);
        if (m_isr) chk(out_read_o == READ_W'(m_rd), "R3", "out_read_o", out_read_o, m_rd);
        else chk(out_cand_o == CAND_W'(m_cd), "R7", "out_cand_o", out_cand_o, m_cd);
      end
      if (out_valid_o && out_ready_i && !out_is_read_o) fwd_cnt++;
      sf = start_valid_i && srdy;
      nf = cnt_valid_i && nrdy;
      cf = cand_valid_i && crdy;
      if (m_ov && out_ready_i) m_ov = 0;
      if (sf) begin
        m_ov = 1; m_isr = 1; m_id = int'(start_id_i); m_rd = int'(start_read_i);
        m_seeds = int'(start_seeds_i); m_sseen = 0; m_sum = 0; m_cseen = 0;
        for (int i = 0; i < DEPTH; i++) m_live[i] = 0;
      end
      if (nf) begin m_sseen++; m_sum += int'(cnt_num_i); end
      if (cf) begin
        m_cseen++;
        home = fold(int'(cand_i)); hit = 0; emp = -1;
        for (int p = 0; p < PROBES; p++) begin
          s = (home + p) % DEPTH;
          if (m_live[s] && m_tag[s] == int'(cand_i)) hit = 1;
          if (!m_live[s] && emp < 0) emp = s;
        end
        if (!hit) begin
          m_ov = 1; m_isr = 0; m_cd = int'(cand_i);
          if (emp >= 0) begin m_live[emp] = 1; m_tag[emp] = int'(cand_i); end
        end
      end
    end
  end

  initial forever begin
    @(posedge clk_i); #1;
    case (rdy_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = 1'($urandom % 2);
      default: out_ready_i = 1'b0;
    endcase
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_live[i] = 0; m_tag[i] = 0; end
    forever begin
      @(posedge clk_i); cycles++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog (phase %s): actual %0d expected <150000 cycles", phase, cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  int cnt_q[$], cand_q[$];

  task automatic send_start(int id, int rd, int seeds);
    start_valid_i = 1; start_id_i = ID_W'(id); start_read_i = READ_W'(rd);
    start_seeds_i = SEEDS_W'(seeds);
    forever begin
      bit r; @(negedge clk_i); r = start_ready_o; @(posedge clk_i); #1;
      if (r) break;
    end
    start_valid_i = 0;
  endtask

  task automatic send_cnts();
    foreach (cnt_q[i]) begin
      cnt_valid_i = 1; cnt_num_i = CNT_W'(cnt_q[i]);
      forever begin
        bit r; @(negedge clk_i); r = cnt_ready_o; @(posedge clk_i); #1;
        if (r) break;
      end
      cnt_valid_i = 0;
    end
  endtask

  task automatic send_cands();
    foreach (cand_q[i]) begin
      cand_valid_i = 1; cand_i = CAND_W'(cand_q[i]);
      forever begin
        bit r; @(negedge clk_i); r = cand_ready_o; @(posedge clk_i); #1;
        if (r) break;
      end
      cand_valid_i = 0;
    end
  endtask

  task automatic wait_idle();
    forever begin
      @(posedge clk_i); #1;
      if (!out_valid_o && !cnt_ready_o && !cand_ready_o && start_ready_o) break;
    end
  endtask

  task automatic do_read(int id, int rd);
    fwd_cnt = 0;
    send_start(id, rd, cnt_q.size());
    fork
      send_cnts();
      send_cands();
    join
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    phase = "R1";
    chk(out_valid_o == 0, "R1", "out_valid_o in reset", out_valid_o, 0);
    chk(start_ready_o == 1, "R1", "start_ready_o in reset", start_ready_o, 1);
    chk(cnt_ready_o == 0 && cand_ready_o == 0, "R1", "cnt/cand ready in reset",
        {cnt_ready_o, cand_ready_o}, 0);
    @(posedge clk_i); #1; rst_ni = 1; run_chk = 1;

    phase = "R7";
    cnt_q = '{2, 0, 3}; cand_q = '{5, 9, 5, 7, 9};
    do_read(8'h11, 32'hCAFE0001);
    chk(fwd_cnt == 3, "R7", "forwards with duplicates and a zero seed (R4)", fwd_cnt, 3);

    phase = "R8";
    cnt_q = '{1}; cand_q = '{5};
    do_read(8'h12, 32'hCAFE0002);
    chk(fwd_cnt == 1, "R8", "value from previous read forwarded again", fwd_cnt, 1);

    phase = "R9";
    cnt_q = '{3, 3}; cand_q = '{16'h0000, 16'h0011, 16'h0101, 16'h0101, 16'h000F, 16'h000F};
    do_read(8'h13, 32'hCAFE0003);
    chk(fwd_cnt == 5, "R9", "overflowed probe forwards repeat", fwd_cnt, 5);

    phase = "R10";
    cnt_q = '{};  cand_q = '{};
    do_read(8'h14, 32'hCAFE0004);
    chk(start_ready_o == 1, "R10", "zero-seed read complete at once", start_ready_o, 1);

    phase = "R2";
    fwd_cnt = 0;
    send_start(8'h15, 32'hCAFE0005, 1);
    cnt_q = '{2}; cand_q = '{33};
    send_cnts(); send_cands();
    start_valid_i = 1; start_id_i = 8'h16; start_read_i = 32'hCAFE0006; start_seeds_i = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); #0.1;
      chk(start_ready_o == 0, "R2", "start held off while read incomplete", start_ready_o, 0);
    end
    @(posedge clk_i); #1;
    cand_valid_i = 1; cand_i = 16'd34;
    begin
      int wait_c = 0;
      bit got_cand = 0, got_start = 0;
      while (!got_start && wait_c < 10) begin
        bit rc, rs;
        @(negedge clk_i); rc = cand_ready_o; rs = start_ready_o;
        @(posedge clk_i); #1;
        if (rc && cand_valid_i) begin cand_valid_i = 0; got_cand = 1; end
        if (rs) got_start = 1;
        wait_c++;
      end
      start_valid_i = 0;
      chk(got_cand && got_start && wait_c <= 3, "R10", "start accepted right after last candidate",
          wait_c, 3);
    end
    cnt_q = '{1}; cand_q = '{34};
    send_cnts(); send_cands(); wait_idle();

    phase = "R11";
    rdy_mode = 2;
    fwd_cnt = 0;
    cnt_q = '{3}; cand_q = '{1, 2, 3};
    fork
      begin
        send_start(8'h17, 32'hCAFE0007, 1);
        fork send_cnts(); send_cands(); join
      end
      begin
        repeat (4) @(posedge clk_i);
        for (int i = 0; i < 10; i++) begin
          @(posedge clk_i); #1;
          chk(out_valid_o && out_is_read_o && out_id_o == 8'h17, "R11", "header held under stall",
              {out_valid_o, out_is_read_o, out_id_o}, {2'b11, 8'h17});
          chk(cand_ready_o == 0, "R11", "candidates stalled (R5)", cand_ready_o, 0);
        end
        rdy_mode = 0;
      end
    join
    wait_idle();
    chk(fwd_cnt == 3, "R11", "all distinct candidates after stall", fwd_cnt, 3);

    phase = "R12";
    for (int r = 0; r < 18; r++) begin
      cnt_q = '{1}; cand_q = '{16'h0042};
      do_read(r, 32'h5000 + r);
      chk(fwd_cnt == 1, "R12", "same value each read across tag wrap", fwd_cnt, 1);
    end

    phase = "R6";
    rdy_mode = 1;
    for (int r = 0; r < 8; r++) begin
      int ns;
      ns = 1 + int'($urandom % 4);
      cnt_q = '{}; cand_q = '{};
      for (int s = 0; s < ns; s++) begin
        int k;
        k = int'($urandom % 4);
        cnt_q.push_back(k);
        for (int j = 0; j < k; j++) cand_q.push_back(int'($urandom % 12) * 17);
      end
      do_read(8'h80 + r, 32'hBEEF0000 + r);
    end
    rdy_mode = 0;
    repeat (4) @(posedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule